// File: doc/BRIEF.md
# Counter Overflow Flag Status Register

This block holds one sticky overflow flag for each of four event counters and for a cycle counter, packed into a single 32-bit register. A one-cycle overflow pulse from a counter sets that counter's flag. The flag stays set until software clears it by writing a one to that bit position. The register is shared by the secure and non-secure states and is not banked, so both states see and clear the same flags.

Software reaches the register through a simple single-cycle access port. The access strobe carries a write/read select, a privilege qualifier and a security-state qualifier. A privileged access always goes through. An unprivileged access goes through only while the user-enable input is high. An unprivileged access with user-enable low is rejected: it raises an undefined-access fault pulse in the same cycle and leaves the flags untouched. Read data is combinational and is valid in the cycle of the read strobe.

Top module: `ovf_flag_reg`

## Requirements
- R1: The flag image has the cycle counter flag at bit 31 and the flags of event counters 3, 2, 1 and 0 at bits 3, 2, 1 and 0. An accepted read returns this image in the same cycle as the strobe.
- R2: A high overflow pulse on a counter input sets that counter's flag at the next clock edge. The flag then stays 1 until it is cleared by a write.
- R3: An accepted write clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. The change is visible from the next cycle.
- R4: When an overflow pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R5: Bits 30 to 4 always read as 0. Writing ones to them has no effect.
- R6: A privileged read or write succeeds and raises no fault, whatever the level of user-enable.
- R7: An unprivileged read or write succeeds when user-enable is 1.
- R8: An unprivileged access with user-enable 0 raises the fault output for exactly the cycle of the strobe. It leaves every flag unchanged and returns read data 0.
- R9: The security-state qualifier has no effect. A flag cleared by a secure write reads as cleared from the non-secure state, and the reverse also holds.
- R10: A synchronous active-high reset clears all flags. Read data is 0 in any cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt_i | input | 4 | Overflow pulses from event counters 3..0 |
| ovf_cyc_i | input | 1 | Overflow pulse from the cycle counter |
| acc_req_i | input | 1 | Access strobe, one cycle per access |
| acc_wr_i | input | 1 | 1 for a write, 0 for a read |
| acc_priv_i | input | 1 | 1 when the access is privileged |
| acc_secure_i | input | 1 | Security state of the access (no effect) |
| acc_wdata_i | input | 32 | Write data, a 1 clears the flag at that position |
| user_en_i | input | 1 | Allows unprivileged access when 1 |
| acc_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| undef_fault_o | output | 1 | Pulse marking a rejected unprivileged access |

## Verification
The assertions take for granted that every input is a known 0 or 1 after reset and that inputs change only between clock edges. They also assume that acc_wr_i, acc_priv_i and the write data are significant only while acc_req_i is high. The bench drives every input on the falling edge from a seeded $urandom stream, so all values are defined and stable across each rising edge. The same stream randomises the qualifiers, and the sticky-flag, precedence and fault properties are exercised over many mixes of privilege, user-enable and collision cases.

// File: rtl/ovf_flag_reg.sv
module ovf_flag_reg #(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 4,
  parameter int CYC_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EVT-1:0] ovf_evt_i,
  input  logic              ovf_cyc_i,
  input  logic              acc_req_i,
  input  logic              acc_wr_i,
  input  logic              acc_priv_i,
  input  logic              acc_secure_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic              user_en_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              undef_fault_o
);

  localparam logic [DATA_W-1:0] EVT_MASK  = DATA_W'((64'd1 << NUM_EVT) - 64'd1);
  localparam logic [DATA_W-1:0] FLAG_MASK = EVT_MASK | (DATA_W'(1) << CYC_BIT);

  logic [DATA_W-1:0] flags_q, set_img, clr_img;
  logic              allowed, rd_ok, wr_ok;
  logic              unused_secure;

  // Single register shared by both security states.
  assign unused_secure = acc_secure_i;

  assign allowed       = acc_priv_i | user_en_i;
  assign rd_ok         = acc_req_i & ~acc_wr_i & allowed;
  assign wr_ok         = acc_req_i &  acc_wr_i & allowed;
  assign undef_fault_o = acc_req_i & ~allowed;

  assign set_img = DATA_W'(ovf_evt_i) | (DATA_W'(ovf_cyc_i) << CYC_BIT);
  assign clr_img = wr_ok ? (acc_wdata_i & FLAG_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= ((flags_q & ~clr_img) | set_img) & FLAG_MASK;
  end

  assign acc_rdata_o = rd_ok ? flags_q : '0;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_img) |=> ((flags_q & $past(set_img)) == $past(set_img))); // R4

  AST_ONLY_EVENTS_RAISE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_img)) == '0)); // R2

  AST_FAULT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    undef_fault_o |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8

  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    undef_fault_o |-> (acc_rdata_o == '0)); // R8

  AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (acc_req_i && acc_priv_i) |-> !undef_fault_o); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_rdata_o & ~FLAG_MASK) == '0); // R5

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> ((flags_q & $past(acc_wdata_i) & ~$past(set_img) & FLAG_MASK) == '0)); // R3

endmodule

// File: tb/ovf_flag_reg_bench.sv
`timescale 1ns/1ps
module ovf_flag_reg_bench;
  localparam real HALF = 10.0;

  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  ovf_evt_i = '0;
  logic        ovf_cyc_i = 1'b0, acc_req_i = 1'b0, acc_wr_i = 1'b0;
  logic        acc_priv_i = 1'b0, acc_secure_i = 1'b0, user_en_i = 1'b0;
  logic [31:0] acc_wdata_i = '0;
  logic [31:0] acc_rdata_o;
  logic        undef_fault_o;

  int checks = 0, fails = 0;
  logic [31:0] exp_flags = '0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  ovf_flag_reg u_ovf_flag_reg (
    .clk(clk), .rst(rst), .ovf_evt_i(ovf_evt_i), .ovf_cyc_i(ovf_cyc_i),
    .acc_req_i(acc_req_i), .acc_wr_i(acc_wr_i), .acc_priv_i(acc_priv_i),
    .acc_secure_i(acc_secure_i), .acc_wdata_i(acc_wdata_i), .user_en_i(user_en_i),
    .acc_rdata_o(acc_rdata_o), .undef_fault_o(undef_fault_o));

  function automatic logic [31:0] set_of(logic [3:0] e, logic c);
    return {c, 27'd0, e};
  endfunction

  function automatic logic [31:0] next_flags(logic [31:0] cur, logic [31:0] st,
      logic req, logic wr, logic priv, logic ue, logic [31:0] wd);
    logic [31:0] clr;
    clr = (req && wr && (priv || ue)) ? (wd & 32'h8000_000F) : '0;
    return (cur & ~clr) | st;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] e, logic c, logic req, logic wr,
      logic priv, logic sec, logic ue, logic [31:0] wd);
    logic [31:0] nxt;
    logic        ok, flt;
    @(negedge clk);
    ovf_evt_i = e; ovf_cyc_i = c; acc_req_i = req; acc_wr_i = wr;
    acc_priv_i = priv; acc_secure_i = sec; user_en_i = ue; acc_wdata_i = wd;
    #1;
    ok  = req && (priv || ue);
    flt = req && !priv && !ue;
    check({tag, " rdata"}, acc_rdata_o, (ok && !wr) ? exp_flags : 32'h0);
    check({tag, " fault"}, {31'd0, undef_fault_o}, {31'd0, flt});
    nxt = next_flags(exp_flags, set_of(e, c), req, wr, priv, ue, wd);
    @(posedge clk);
    exp_flags = nxt;
  endtask

  task automatic rd(string tag, logic priv, logic sec, logic ue);
    step(tag, 4'd0, 1'b0, 1'b1, 1'b0, priv, sec, ue, 32'h0);
  endtask

  task automatic wr(string tag, logic priv, logic sec, logic ue, logic [31:0] wd);
    step(tag, 4'd0, 1'b0, 1'b1, 1'b1, priv, sec, ue, wd);
  endtask

  task automatic idle(string tag, logic [3:0] e, logic c);
    step(tag, e, c, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    exp_flags = '0;
    rd("R10 reset", 1'b1, 1'b0, 1'b0);
    idle("R10 idle", 4'd0, 1'b0);

    // Single events, each lands on its own bit
    idle("R2 evt0", 4'b0001, 1'b0);
    rd("R1 evt0", 1'b1, 1'b0, 1'b0);
    idle("R2 cyc", 4'b0000, 1'b1);
    rd("R1 cyc", 1'b1, 1'b0, 1'b0);
    idle("R2 evt3", 4'b1000, 1'b0);
    idle("R2 hold", 4'b0000, 1'b0);
    rd("R2 sticky", 1'b1, 1'b1, 1'b0);

    // Write-one-to-clear and write-zero-no-effect
    wr("R3 w0", 1'b1, 1'b0, 1'b0, 32'h0);
    rd("R3 w0 read", 1'b1, 1'b0, 1'b0);
    wr("R3 w1 bit0", 1'b1, 1'b0, 1'b0, 32'h0000_0001);
    rd("R3 w1 read", 1'b1, 1'b0, 1'b0);

    // Reserved bits
    idle("R5 fill", 4'b0110, 1'b0);
    wr("R5 rsvd write", 1'b1, 1'b0, 1'b0, 32'h7FFF_FFF0);
    rd("R5 rsvd read", 1'b1, 1'b0, 1'b0);

    // Set beats clear in the same cycle
    step("R4 collide", 4'b0100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h8000_0004);
    rd("R4 after", 1'b1, 1'b0, 1'b0);

    // Unprivileged with user-enable low
    rd("R8 user read", 1'b0, 1'b0, 1'b0);
    wr("R8 user write", 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd("R8 unchanged", 1'b1, 1'b0, 1'b0);

    // Privileged regardless of user-enable
    rd("R6 priv ue1", 1'b1, 1'b0, 1'b1);
    wr("R6 priv write", 1'b1, 1'b1, 1'b0, 32'h0000_0002);
    rd("R6 read", 1'b1, 1'b0, 1'b0);

    // Unprivileged with user-enable high
    rd("R7 user read", 1'b0, 1'b0, 1'b1);
    wr("R7 user write", 1'b0, 1'b0, 1'b1, 32'h8000_0000);
    rd("R7 read", 1'b0, 1'b1, 1'b1);

    // Shared across security states
    idle("R9 fill", 4'b1111, 1'b1);
    wr("R9 secure clr", 1'b1, 1'b1, 1'b0, 32'h0000_0005);
    rd("R9 nonsec read", 1'b1, 1'b0, 1'b0);
    wr("R9 nonsec clr", 1'b1, 1'b0, 1'b0, 32'h8000_0008);
    rd("R9 secure read", 1'b1, 1'b1, 1'b0);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  e;
      logic        c, rq, w, p, s, u;
      logic [31:0] d;
      e  = ($urandom % 8 == 0) ? 4'($urandom) : 4'd0;
      c  = ($urandom % 10 == 0);
      rq = ($urandom % 2 == 0);
      w  = $urandom % 2;
      p  = $urandom % 2;
      s  = $urandom % 2;
      u  = $urandom % 2;
      d  = $urandom;
      step("R2 random", e, c, rq, w, p, s, u, d);
    end
    rd("R1 final", 1'b1, 1'b0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule